// File: doc/BRIEF.md
# Serial Link Training and Power State Controller

This block sequences one end of a high-speed serial link through initialization, training, normal operation, three graded low-power states, retraining, reset by the partner, two test modes, an error state and a disabled state. It does not see the analog front end. It acts on abstract indications from the PHY and the link layer: termination found, low-frequency signalling handshake done, bit lock, symbol lock, equalization done, activity, wake, error and timeout strobes. It also acts on two software commands.

The controller drives a 4-bit state code and three enables: the high-speed transmitter, the low-frequency signalling generator and packet traffic. Two counters sit under the state register. The inactivity counter compares against two idle limits supplied as inputs; a limit of zero turns that descent off. The exit counter times the wake-up latency of each low-power state and the length of a partner-requested reset. Those latencies are parameters, ordered shallow to deep.

The twelve states are: RX_DETECT, POLLING, U0, U1, U2, U3, RECOVERY, HOT_RESET, LOOPBACK, COMPLIANCE, INACTIVE and DISABLED. The transitions are:
- RX_DETECT goes to POLLING when termination is found.
- POLLING goes to U0 when training completes. It goes to COMPLIANCE on a polling timeout.
- U0 goes to RECOVERY on an error, to U3 on a suspend request, and to U1 on inactivity.
- U1 goes to U2 on further inactivity.
- U1, U2 and U3 go to RECOVERY once their wake latency has elapsed.
- RECOVERY goes to HOT_RESET, LOOPBACK, U0 or INACTIVE.
- HOT_RESET goes to U0.
- LOOPBACK goes to RX_DETECT.
- COMPLIANCE, INACTIVE and DISABLED go to RX_DETECT on a clear command.
- Any state goes to DISABLED on a disable command.

Top module: `link_train_fsm`

## Requirements
- R1: Asynchronous active-low reset puts the controller in RX_DETECT (code 0) with tx_en, lfps_en and pkt_en all low. Reset has this effect whenever it is asserted, including mid-run.
- R2: The state codes are RX_DETECT=0, POLLING=1, U0=2, U1=3, U2=4, U3=5, RECOVERY=6, HOT_RESET=7, LOOPBACK=8, COMPLIANCE=9, INACTIVE=10 and DISABLED=11. pkt_en is high only in U0. tx_en is high exactly in POLLING, U0, RECOVERY, HOT_RESET, LOOPBACK and COMPLIANCE. No other code ever appears.
- R3: RX_DETECT moves to POLLING on the edge after term_detected is high. Without term_detected it stays in RX_DETECT, whatever the lock inputs show.
- R4: POLLING moves to U0 only when lfps_done, bit_lock, sym_lock and eq_done are all high in the same cycle. Otherwise poll_timeout moves it to COMPLIANCE. lfps_en is high in POLLING.
- R5: In U0, once link_active has been low for idle_u1 consecutive cycles, the state becomes U1. In U1, idle_u2 further idle cycles lead to U2. Any cycle with link_active high restarts the count. A limit of zero disables that step.
- R6: In U0, the priority is link_err (to RECOVERY) first, then suspend_req (to U3), then inactivity (to U1).
- R7: A wake_req pulse in U1, U2 or U3 keeps the state there for EXIT_U1, EXIT_U2 or EXIT_U3 cycles respectively, with lfps_en high, and then moves to RECOVERY. The state never goes straight from U1, U2 or U3 to U0.
- R8: In RECOVERY, the priority is hot_reset_req (to HOT_RESET), then loopback_req (to LOOPBACK), then bit_lock and sym_lock both high (to U0), then recov_timeout (to INACTIVE).
- R9: HOT_RESET lasts HOT_LEN cycles regardless of inputs and then moves to U0.
- R10: LOOPBACK holds while loopback_req is high and moves to RX_DETECT when it drops.
- R11: COMPLIANCE and INACTIVE ignore every input except sw_clear, which moves them to RX_DETECT, and sw_disable.
- R12: sw_disable moves any state to DISABLED, where tx_en and lfps_en are low. DISABLED is left only by sw_clear, to RX_DETECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_detected | input | 1 | Far-end receiver termination found |
| lfps_done | input | 1 | Low-frequency signalling handshake complete |
| bit_lock | input | 1 | Receiver bit lock |
| sym_lock | input | 1 | Receiver symbol lock |
| eq_done | input | 1 | Equalization finished |
| link_active | input | 1 | Traffic seen this cycle |
| wake_req | input | 1 | Request to leave a low-power state |
| suspend_req | input | 1 | Request to suspend from U0 |
| link_err | input | 1 | Link error strobe |
| hot_reset_req | input | 1 | Partner reset request during retraining |
| loopback_req | input | 1 | Loopback test request, held for its duration |
| poll_timeout | input | 1 | Polling timeout strobe |
| recov_timeout | input | 1 | Retraining timeout strobe |
| sw_disable | input | 1 | Software command: disable the link |
| sw_clear | input | 1 | Software command: restart from detection |
| idle_u1 | input | IDLE_W | Idle cycles from U0 to U1, 0 disables |
| idle_u2 | input | IDLE_W | Idle cycles from U1 to U2, 0 disables |
| link_state | output | 4 | Current state code |
| tx_en | output | 1 | High-speed transmitter enable |
| lfps_en | output | 1 | Low-frequency signalling generator enable |
| pkt_en | output | 1 | Packet traffic permitted |

## Verification
The state code is a port, so a wrong internal state shows as a wrong code on the edge after the faulty transition, and the enables go wrong in the same cycle. Errors in the counters show only as timing: an exit latency or idle descent that is off by one cycle, measured from the wake pulse or from entry into the state. Priority errors in U0 and RECOVERY show when conflicting requests are presented together in one cycle. In the sticky states, ignored inputs are proven ignored because the code holds on the next edge.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [3:0] {
        ST_RX_DETECT  = 4'd0,
        ST_POLLING    = 4'd1,
        ST_U0         = 4'd2,
        ST_U1         = 4'd3,
        ST_U2         = 4'd4,
        ST_U3         = 4'd5,
        ST_RECOVERY   = 4'd6,
        ST_HOT_RESET  = 4'd7,
        ST_LOOPBACK   = 4'd8,
        ST_COMPLIANCE = 4'd9,
        ST_INACTIVE   = 4'd10,
        ST_DISABLED   = 4'd11
    } lt_state_e;

    function automatic logic is_low_power(lt_state_e s);
        return (s == ST_U1) || (s == ST_U2) || (s == ST_U3);
    endfunction

endpackage

// File: rtl/lt_idle_timer.sv
module lt_idle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         active,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || active) begin
            cnt_q <= '0;
        end else if (cnt_q != {W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fires in the last idle cycle of the programmed window.
    assign hit = (limit != '0) && !active && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/lt_exit_timer.sv
module lt_exit_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    input  logic         clear,
    output logic         busy,
    output logic         done
);
    logic [W-1:0] cnt_q;
    logic         busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= load - 1'b1;
            busy_q <= 1'b1;
        end else if (clear) begin
            busy_q <= 1'b0;
        end else if (busy_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/link_train_fsm.sv
module link_train_fsm
    import lt_pkg::*;
#(
    parameter int IDLE_W  = 16,
    parameter int EXIT_U1 = 10,
    parameter int EXIT_U2 = 100,
    parameter int EXIT_U3 = 1000,
    parameter int HOT_LEN = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              term_detected,
    input  logic              lfps_done,
    input  logic              bit_lock,
    input  logic              sym_lock,
    input  logic              eq_done,
    input  logic              link_active,
    input  logic              wake_req,
    input  logic              suspend_req,
    input  logic              link_err,
    input  logic              hot_reset_req,
    input  logic              loopback_req,
    input  logic              poll_timeout,
    input  logic              recov_timeout,
    input  logic              sw_disable,
    input  logic              sw_clear,
    input  logic [IDLE_W-1:0] idle_u1,
    input  logic [IDLE_W-1:0] idle_u2,
    output logic [3:0]        link_state,
    output logic              tx_en,
    output logic              lfps_en,
    output logic              pkt_en
);
    localparam int EXIT_MAX = (EXIT_U3 > HOT_LEN) ? EXIT_U3 : HOT_LEN;
    localparam int EXIT_W   = $clog2(EXIT_MAX + 1);

    lt_state_e st_q, st_d;

    logic              train_full, retrain_ok, in_lp, st_change;
    logic              idle_hit, exit_busy, exit_done, exit_start;
    logic [IDLE_W-1:0] idle_lim;
    logic [EXIT_W-1:0] exit_len;

    assign train_full = lfps_done && bit_lock && sym_lock && eq_done;
    assign retrain_ok = bit_lock && sym_lock;
    assign in_lp      = is_low_power(st_q);
    assign st_change  = (st_d != st_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RX_DETECT;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state selection
    always_comb begin
        st_d = st_q;
        if (sw_disable && st_q != ST_DISABLED) begin
            st_d = ST_DISABLED;
        end else begin
            unique case (st_q)
                ST_RX_DETECT: begin
                    if (term_detected) st_d = ST_POLLING;
                end
                ST_POLLING: begin
                    if (train_full)        st_d = ST_U0;
                    else if (poll_timeout) st_d = ST_COMPLIANCE;
                end
                ST_U0: begin
                    if (link_err)         st_d = ST_RECOVERY;
                    else if (suspend_req) st_d = ST_U3;
                    else if (idle_hit)    st_d = ST_U1;
                end
                ST_U1: begin
                    if (exit_done) st_d = ST_RECOVERY;
                    else if (idle_hit && !exit_busy && !wake_req) st_d = ST_U2;
                end
                ST_U2, ST_U3: begin
                    if (exit_done) st_d = ST_RECOVERY;
                end
                ST_RECOVERY: begin
                    if (hot_reset_req)      st_d = ST_HOT_RESET;
                    else if (loopback_req)  st_d = ST_LOOPBACK;
                    else if (retrain_ok)    st_d = ST_U0;
                    else if (recov_timeout) st_d = ST_INACTIVE;
                end
                ST_HOT_RESET: begin
                    if (exit_done) st_d = ST_U0;
                end
                ST_LOOPBACK: begin
                    if (!loopback_req) st_d = ST_RX_DETECT;
                end
                ST_COMPLIANCE, ST_INACTIVE, ST_DISABLED: begin
                    if (sw_clear) st_d = ST_RX_DETECT;
                end
                default: st_d = ST_RX_DETECT;
            endcase
        end
    end

    // Counter controls
    assign idle_lim = (st_q == ST_U1) ? idle_u2 : idle_u1;

    assign exit_start = (st_d == ST_HOT_RESET && st_q != ST_HOT_RESET) ||
                        (in_lp && wake_req && !exit_busy && !st_change);

    always_comb begin
        unique case (st_q)
            ST_U1:   exit_len = EXIT_W'(EXIT_U1);
            ST_U2:   exit_len = EXIT_W'(EXIT_U2);
            ST_U3:   exit_len = EXIT_W'(EXIT_U3);
            default: exit_len = EXIT_W'(HOT_LEN);
        endcase
    end

    lt_idle_timer #(.W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st_change),
        .active  (link_active),
        .limit   (idle_lim),
        .hit     (idle_hit)
    );

    lt_exit_timer #(.W(EXIT_W)) u_exit (
        .clk   (clk),
        .rst_n (rst_n),
        .start (exit_start),
        .load  (exit_len),
        .clear (st_change),
        .busy  (exit_busy),
        .done  (exit_done)
    );

    // Outputs
    always_comb begin
        tx_en   = 1'b0;
        lfps_en = 1'b0;
        pkt_en  = 1'b0;
        unique case (st_q)
            ST_POLLING: begin
                tx_en   = 1'b1;
                lfps_en = 1'b1;
            end
            ST_U0: begin
                tx_en  = 1'b1;
                pkt_en = 1'b1;
            end
            ST_U1, ST_U2, ST_U3: lfps_en = exit_busy;
            ST_RECOVERY, ST_HOT_RESET, ST_LOOPBACK, ST_COMPLIANCE: tx_en = 1'b1;
            default: ;
        endcase
    end

    assign link_state = st_q;
endmodule

// File: rtl/lt_checker.sv
module lt_checker
    import lt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       term_detected,
    input logic       lfps_done,
    input logic       bit_lock,
    input logic       sym_lock,
    input logic       eq_done,
    input logic       sw_disable,
    input logic       sw_clear,
    input logic [3:0] link_state,
    input logic       tx_en,
    input logic       lfps_en,
    input logic       pkt_en
);
    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_state <= 4'd11);

    // R2
    pkt_only_u0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_en |-> link_state == ST_U0);

    // R3
    detect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_RX_DETECT && !term_detected) |=> link_state != ST_POLLING);

    // R4
    poll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_POLLING && !(lfps_done && bit_lock && sym_lock && eq_done))
        |=> link_state != ST_U0);

    // R7
    lp_no_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_U1 || link_state == ST_U2 || link_state == ST_U3)
        |=> link_state != ST_U0);

    // R11
    inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_INACTIVE && !sw_clear && !sw_disable) |=> link_state == ST_INACTIVE);

    // R11
    compliance_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_COMPLIANCE && !sw_clear && !sw_disable) |=> link_state == ST_COMPLIANCE);

    // R12
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_state == ST_DISABLED |-> (!tx_en && !lfps_en));

    // R12
    disable_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_disable |=> link_state == ST_DISABLED);
endmodule

bind link_train_fsm lt_checker u_lt_checker (.*);

// File: tb/link_train_fsm_test.sv
module link_train_fsm_test;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 8;
    localparam int L1 = 2, L2 = 4, L3 = 6, LH = 3;

    localparam logic [3:0] S_RXD = 4'd0, S_POLL = 4'd1, S_U0 = 4'd2, S_U1 = 4'd3,
                           S_U2 = 4'd4, S_U3 = 4'd5, S_REC = 4'd6, S_HOT = 4'd7,
                           S_LB = 4'd8, S_CMP = 4'd9, S_INA = 4'd10, S_DIS = 4'd11;

    localparam logic [14:0] I_NONE = 15'd0;
    localparam logic [14:0] I_TERM = 15'd1 << 0,  I_LFPS = 15'd1 << 1,  I_BL  = 15'd1 << 2;
    localparam logic [14:0] I_SL   = 15'd1 << 3,  I_EQ   = 15'd1 << 4,  I_ACT = 15'd1 << 5;
    localparam logic [14:0] I_WAKE = 15'd1 << 6,  I_SUSP = 15'd1 << 7,  I_ERR = 15'd1 << 8;
    localparam logic [14:0] I_HOT  = 15'd1 << 9,  I_LB   = 15'd1 << 10, I_PTO = 15'd1 << 11;
    localparam logic [14:0] I_RTO  = 15'd1 << 12, I_DIS  = 15'd1 << 13, I_CLR = 15'd1 << 14;
    localparam logic [14:0] I_ALL  = I_LFPS | I_BL | I_SL | I_EQ;

    localparam int NV = 39;
    localparam logic [18:0] VEC [NV] = '{
        {I_NONE, S_RXD}, {I_ALL, S_RXD}, {I_TERM, S_POLL},
        {I_LFPS | I_BL | I_SL, S_POLL}, {I_BL | I_SL | I_EQ, S_POLL},
        {I_ALL, S_U0}, {I_ERR, S_REC}, {I_BL | I_SL, S_U0}, {I_SUSP, S_U3},
        {I_DIS, S_DIS}, {I_TERM | I_BL, S_DIS}, {I_CLR, S_RXD},
        {I_TERM, S_POLL}, {I_PTO, S_CMP}, {I_TERM | I_ALL, S_CMP}, {I_CLR, S_RXD},
        {I_TERM, S_POLL}, {I_ALL, S_U0}, {I_ERR, S_REC}, {I_RTO, S_INA},
        {I_TERM | I_BL | I_SL | I_ERR | I_WAKE, S_INA}, {I_CLR, S_RXD},
        {I_TERM, S_POLL}, {I_ALL, S_U0}, {I_ERR, S_REC},
        {I_HOT | I_LB | I_BL | I_SL | I_RTO, S_HOT},
        {I_NONE, S_HOT}, {I_NONE, S_HOT}, {I_NONE, S_U0},
        {I_ERR, S_REC}, {I_LB | I_BL | I_SL | I_RTO, S_LB}, {I_LB, S_LB}, {I_NONE, S_RXD},
        {I_TERM, S_POLL}, {I_ALL, S_U0}, {I_ERR, S_REC}, {I_BL | I_SL | I_RTO, S_U0},
        {I_DIS, S_DIS}, {I_CLR, S_RXD}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [14:0] drv = '0;
    logic [IW-1:0] idle_u1 = '0, idle_u2 = '0;
    logic [3:0] link_state;
    logic tx_en, lfps_en, pkt_en;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_train_fsm #(
        .IDLE_W(IW), .EXIT_U1(L1), .EXIT_U2(L2), .EXIT_U3(L3), .HOT_LEN(LH)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .term_detected(drv[0]), .lfps_done(drv[1]), .bit_lock(drv[2]), .sym_lock(drv[3]),
        .eq_done(drv[4]), .link_active(drv[5]), .wake_req(drv[6]), .suspend_req(drv[7]),
        .link_err(drv[8]), .hot_reset_req(drv[9]), .loopback_req(drv[10]),
        .poll_timeout(drv[11]), .recov_timeout(drv[12]), .sw_disable(drv[13]),
        .sw_clear(drv[14]), .idle_u1(idle_u1), .idle_u2(idle_u2),
        .link_state(link_state), .tx_en(tx_en), .lfps_en(lfps_en), .pkt_en(pkt_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_tx(input logic [3:0] s);
        return (s == S_POLL) || (s == S_U0) || (s == S_REC) || (s == S_HOT) ||
               (s == S_LB) || (s == S_CMP);
    endfunction

    task automatic step(input logic [14:0] v);
        drv = v;
        @(negedge clk);
    endtask

    task automatic wait_state(input logic [3:0] target, output int n);
        n = 0;
        while (link_state != target && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure_exit(input int lat, input string tag);
        int n;
        drv = I_WAKE;
        @(negedge clk);
        drv = I_NONE;
        chk({tag, " lfps_en during exit"}, int'(lfps_en), 1);
        n = 0;
        while (link_state != S_REC && n < 40) begin
            if (link_state == S_U0) chk({tag, " direct to U0"}, int'(link_state), int'(S_REC));
            @(negedge clk);
            n++;
        end
        chk({tag, " exit latency"}, n, lat);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 reset state", int'(link_state), int'(S_RXD));
        chk("R1 reset tx_en", int'(tx_en), 0);
        chk("R1 reset lfps_en", int'(lfps_en), 0);
        chk("R1 reset pkt_en", int'(pkt_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Single-step transitions (R2 R3 R4 R6 R8 R9 R10 R11 R12)
        for (int i = 0; i < NV; i++) begin
            logic [3:0] e;
            e = VEC[i][3:0];
            step(VEC[i][18:4]);
            chk($sformatf("R2 vec%0d state", i), int'(link_state), int'(e));
            chk($sformatf("R2 vec%0d tx_en", i), int'(tx_en), int'(exp_tx(e)));
            chk($sformatf("R2 vec%0d pkt_en", i), int'(pkt_en), int'(e == S_U0));
            chk($sformatf("R4 vec%0d lfps_en", i), int'(lfps_en), int'(e == S_POLL));
        end

        // R1: mid-run reset
        step(I_TERM);
        step(I_ALL);
        chk("R1 reach U0", int'(link_state), int'(S_U0));
        rst_n = 1'b0;
        drv = I_NONE;
        idle_u1 = 8'd3;
        idle_u2 = 8'd4;
        @(negedge clk);
        chk("R1 mid-run reset state", int'(link_state), int'(S_RXD));
        chk("R1 mid-run reset pkt_en", int'(pkt_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: idle descent U0 -> U1 -> U2
        step(I_TERM);
        step(I_ALL);
        drv = I_NONE;
        wait_state(S_U1, n);
        chk("R5 U0 to U1 idle cycles", n, 3);
        chk("R2 U1 tx_en", int'(tx_en), 0);
        chk("R2 U1 lfps_en before wake", int'(lfps_en), 0);
        wait_state(S_U2, n);
        chk("R5 U1 to U2 idle cycles", n, 4);

        // R7: exits with ordered latencies
        measure_exit(L2, "R7 U2");
        step(I_BL | I_SL);
        chk("R8 retrain to U0", int'(link_state), int'(S_U0));
        drv = I_NONE;
        wait_state(S_U1, n);
        chk("R5 second U1 entry", n, 3);
        measure_exit(L1, "R7 U1");
        step(I_BL | I_SL);
        step(I_SUSP);
        chk("R6 suspend to U3", int'(link_state), int'(S_U3));
        drv = I_NONE;
        measure_exit(L3, "R7 U3");

        // R5: activity restarts the count, zero limit disables
        step(I_BL | I_SL);
        drv = I_ACT;
        repeat (10) @(negedge clk);
        chk("R5 activity holds U0", int'(link_state), int'(S_U0));
        drv = I_NONE;
        idle_u1 = 8'd0;
        repeat (10) @(negedge clk);
        chk("R5 zero limit holds U0", int'(link_state), int'(S_U0));

        // R6: error beats suspend in U0
        step(I_ERR | I_SUSP);
        chk("R6 error priority", int'(link_state), int'(S_REC));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule